// File: doc/BRIEF.md
# Bus Error Detection and Logging Unit

This block sits beside a processor-side bus port and watches it for two kinds of error. The first is bad odd parity on processor write data: each byte lane has its own parity bit. The second is an error indication that a downstream bus slave returns to the bus master. Each source has its own enable bit and its own sticky detect bit. The block logs only the first error. After that, all further logging is frozen until software acknowledges the logged error by writing 1 to its detect bit.

A logged error can pull an active-low machine-check line low for a fixed number of cycles. A separate control bit drives a lock-error output, which tells the downstream slaves to trap and hold their own error status. A small register port gives access to the control and detect registers. The bus transfer itself is not touched: a write with bad parity completes as usual, and no address or attribute is captured.

Top module: `bus_err_logger`

## Requirements
- R1: Parity is checked only while `wr_valid_i` is high. Lane k is `wr_data_i[8k+7:8k]` together with `wr_par_i[k]`, and that lane is correct when its nine bits hold an odd number of ones. No error is logged in a cycle where `wr_valid_i` and `merr_i` are both low.
- R2: A parity error is logged into detect bit 0 (address 1) only when parity enable, control bit 0 (address 0), is set. The detect bit becomes visible one cycle after the offending write.
- R3: A cycle with `merr_i` high is logged into detect bit 1 only when master-error enable, control bit 1, is set.
- R4: A synchronous reset `rst_i` clears all control and detect bits, drives `mcheck_n_o` high and drives `lock_err_o` low.
- R5: When control bit 2 is set, a newly logged error drives `mcheck_n_o` low for exactly MC_CYCLES cycles (default 2), starting the cycle after the error. When control bit 2 is clear, `mcheck_n_o` stays high.
- R6: While any detect bit is set, no new error is logged. An error in the same cycle as the write that clears the last detect bit is dropped.
- R7: A parity error and a master error in the same cycle, with no error pending, set both detect bits.
- R8: Writing 1 to a detect bit clears it. Writing 0 to a detect bit leaves it unchanged.
- R9: `lock_err_o` follows control bit 3 and changes one cycle after the register write.
- R10: Address 0 reads back control bits [3:0]. Address 1 reads detect bits [1:0] with the upper bits zero. Other addresses read 0 and ignore writes. Reads have no side effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| wr_valid_i | input | 1 | Processor write data cycle |
| wr_data_i | input | DATA_W | Processor write data |
| wr_par_i | input | DATA_W/8 | Odd parity, one bit per byte lane |
| merr_i | input | 1 | Master-error indication from downstream slave |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | 4 | Register write data |
| reg_rdata_o | output | 4 | Register read data (combinational) |
| mcheck_n_o | output | 1 | Machine check, active low |
| lock_err_o | output | 1 | Ask downstream slaves to hold error status |

## Verification
The hardest case to reach is a new error that arrives in the same cycle as the write that clears the pending one. It should be dropped, because the logging block is still in force at that edge. The bench reaches it by first logging a master error, then driving `merr_i` and the clearing register write at the same negative edge. It then checks that the detect register reads zero, and that a later error is logged again. The simultaneous two-source case is reached in a similar way, with a bad-parity write and `merr_i` driven in one cycle.

// File: rtl/bel_pkg.sv
package bel_pkg;
    localparam int CTRL_W = 4;
    localparam int STAT_W = 2;

    typedef struct packed {
        logic lock_en;
        logic mc_en;
        logic merr_en;
        logic par_en;
    } ctrl_t;

    typedef struct packed {
        logic merr;
        logic par;
    } stat_t;

    typedef struct packed {
        ctrl_t ctrl;
        stat_t stat;
    } regs_state_t;
endpackage

// File: rtl/bel_parity.sv
module bel_parity #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8
) (
    input  logic                       valid_i,
    input  logic [DATA_W-1:0]          data_i,
    input  logic [DATA_W/LANE_W-1:0]   par_i,
    output logic                       bad_o
);
    localparam int LANES = DATA_W / LANE_W;

    logic [LANES-1:0] lane_ok;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lane_ok[k] = ^{data_i[k*LANE_W +: LANE_W], par_i[k]};
    end

    always_comb begin
        bad_o = valid_i & ~(&lane_ok);
    end
endmodule

// File: rtl/bel_mc_stretch.sv
module bel_mc_stretch #(
    parameter int MC_CYCLES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic fire_i,
    output logic mc_n_o
);
    localparam int CNT_W = $clog2(MC_CYCLES + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } mc_state_t;

    mc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fire_i) begin
            st_d.cnt = CNT_W'(MC_CYCLES);
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mc_n_o = (st_q.cnt == '0);
endmodule

// File: rtl/bel_regs.sv
module bel_regs
    import bel_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              par_bad_i,
    input  logic              merr_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CTRL_W-1:0] wdata_i,
    output logic [CTRL_W-1:0] rdata_o,
    output ctrl_t             ctrl_o,
    output stat_t             stat_o,
    output logic              log_o
);
    localparam logic [ADDR_W-1:0] ADR_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADR_STAT = ADDR_W'(1);

    regs_state_t st_d, st_q;
    logic        pending;
    logic        par_hit;
    logic        merr_hit;
    stat_t       clr_mask;

    always_comb begin
        st_d     = st_q;
        pending  = (st_q.stat != '0);
        par_hit  = par_bad_i & st_q.ctrl.par_en & ~pending;
        merr_hit = merr_i & st_q.ctrl.merr_en & ~pending;
        clr_mask = '0;

        if (we_i && addr_i == ADR_CTRL) begin
            st_d.ctrl = ctrl_t'(wdata_i);
        end
        if (we_i && addr_i == ADR_STAT) begin
            clr_mask = stat_t'(wdata_i[STAT_W-1:0]);
        end

        st_d.stat.par  = (st_q.stat.par  & ~clr_mask.par)  | par_hit;
        st_d.stat.merr = (st_q.stat.merr & ~clr_mask.merr) | merr_hit;

        log_o = (par_hit | merr_hit) & st_q.ctrl.mc_en;

        unique case (addr_i)
            ADR_CTRL: rdata_o = st_q.ctrl;
            ADR_STAT: rdata_o = CTRL_W'(st_q.stat);
            default:  rdata_o = '0;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_o = st_q.ctrl;
    assign stat_o = st_q.stat;
endmodule

// File: rtl/bus_err_logger.sv
module bus_err_logger
    import bel_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 2,
    parameter int MC_CYCLES = 2
) (
    input  logic                  clk_i,
    input  logic                  rst_i,
    input  logic                  wr_valid_i,
    input  logic [DATA_W-1:0]     wr_data_i,
    input  logic [DATA_W/8-1:0]   wr_par_i,
    input  logic                  merr_i,
    input  logic                  reg_we_i,
    input  logic [ADDR_W-1:0]     reg_addr_i,
    input  logic [CTRL_W-1:0]     reg_wdata_i,
    output logic [CTRL_W-1:0]     reg_rdata_o,
    output logic                  mcheck_n_o,
    output logic                  lock_err_o
);
    logic  par_bad;
    logic  log_fire;
    ctrl_t ctrl_w;
    stat_t stat_w;

    bel_parity #(
        .DATA_W (DATA_W),
        .LANE_W (8)
    ) u_parity (
        .valid_i (wr_valid_i),
        .data_i  (wr_data_i),
        .par_i   (wr_par_i),
        .bad_o   (par_bad)
    );

    bel_regs #(
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .par_bad_i (par_bad),
        .merr_i    (merr_i),
        .we_i      (reg_we_i),
        .addr_i    (reg_addr_i),
        .wdata_i   (reg_wdata_i),
        .rdata_o   (reg_rdata_o),
        .ctrl_o    (ctrl_w),
        .stat_o    (stat_w),
        .log_o     (log_fire)
    );

    bel_mc_stretch #(
        .MC_CYCLES (MC_CYCLES)
    ) u_mc (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .fire_i (log_fire),
        .mc_n_o (mcheck_n_o)
    );

    assign lock_err_o = ctrl_w.lock_en;
endmodule

// File: rtl/bel_checker.sv
module bel_checker
    import bel_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              wr_valid_i,
    input logic              merr_i,
    input logic              reg_we_i,
    input logic [ADDR_W-1:0] reg_addr_i,
    input logic [CTRL_W-1:0] reg_wdata_i,
    input logic              mcheck_n_o,
    input ctrl_t             ctrl,
    input stat_t             stat
);
    logic clr_wr;
    assign clr_wr = reg_we_i && (reg_addr_i == ADDR_W'(1)) && (reg_wdata_i[1:0] != 2'b00);

    AST_NO_LOG_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
        (!wr_valid_i && !merr_i) |=> ((stat & ~$past(stat)) == '0)); // R1

    AST_MERR_LOGGED: assert property (@(posedge clk_i) disable iff (rst_i)
        (merr_i && ctrl.merr_en && stat == '0) |=> stat.merr); // R3

    AST_MC_MIN_WIDTH: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(mcheck_n_o) |=> !mcheck_n_o); // R5

    AST_MC_ON_NEW_LOG: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(mcheck_n_o) |-> ($past(stat) == '0 && stat != '0)); // R5

    AST_LOG_BLOCKED: assert property (@(posedge clk_i) disable iff (rst_i)
        (stat != '0 && !clr_wr) |=> ((stat & ~$past(stat)) == '0)); // R6

    AST_W0_KEEPS: assert property (@(posedge clk_i) disable iff (rst_i)
        (reg_we_i && reg_addr_i == ADDR_W'(1) && reg_wdata_i[1:0] == 2'b00 && stat != '0)
        |=> $stable(stat)); // R8
endmodule

bind bus_err_logger bel_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .wr_valid_i  (wr_valid_i),
    .merr_i      (merr_i),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .mcheck_n_o  (mcheck_n_o),
    .ctrl        (ctrl_w),
    .stat        (stat_w)
);

// File: tb/bus_err_logger_test.sv
module bus_err_logger_test;
    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;

    logic              clk = 1'b0;
    logic              rst;
    logic              wr_valid;
    logic [DATA_W-1:0] wr_data;
    logic [LANES-1:0]  wr_par;
    logic              merr;
    logic              reg_we;
    logic [1:0]        reg_addr;
    logic [3:0]        reg_wdata;
    logic [3:0]        reg_rdata;
    logic              mcheck_n;
    logic              lock_err;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    bus_err_logger #(.DATA_W(DATA_W), .ADDR_W(2), .MC_CYCLES(2)) uut (
        .clk_i       (clk),
        .rst_i       (rst),
        .wr_valid_i  (wr_valid),
        .wr_data_i   (wr_data),
        .wr_par_i    (wr_par),
        .merr_i      (merr),
        .reg_we_i    (reg_we),
        .reg_addr_i  (reg_addr),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .mcheck_n_o  (mcheck_n),
        .lock_err_o  (lock_err)
    );

    function automatic logic [LANES-1:0] good_par(logic [DATA_W-1:0] d);
        logic [LANES-1:0] p;
        for (int k = 0; k < LANES; k++) p[k] = ~^d[k*8 +: 8];
        return p;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        wr_valid = 0; wr_data = '0; wr_par = '0; merr = 0;
        reg_we = 0; reg_addr = '0; reg_wdata = '0;
    endtask

    task automatic reg_wr(logic [1:0] a, logic [3:0] d);
        @(negedge clk);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic reg_rd(logic [1:0] a, output logic [3:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // one bus cycle; returns at the negedge after the edge that samples it
    task automatic bus(logic v, logic [DATA_W-1:0] d, logic [LANES-1:0] p, logic m);
        @(negedge clk);
        wr_valid = v; wr_data = d; wr_par = p; merr = m;
        @(negedge clk);
        wr_valid = 0; merr = 0;
    endtask

    task automatic t_reset();
        logic [3:0] r;
        rst = 1; idle();
        repeat (3) @(negedge clk);
        rst = 0;
        reg_rd(2'd0, r); chk("R4 ctrl after reset", r, 0);
        reg_rd(2'd1, r); chk("R4 status after reset", r, 0);
        chk("R4 mcheck_n after reset", mcheck_n, 1);
        chk("R4 lock_err after reset", lock_err, 0);
    endtask

    task automatic t_regmap();
        logic [3:0] r;
        reg_wr(2'd0, 4'hF);
        reg_rd(2'd0, r); chk("R10 ctrl readback", r, 4'hF);
        chk("R9 lock_err set", lock_err, 1);
        reg_rd(2'd2, r); chk("R10 addr2 reads zero", r, 0);
        reg_wr(2'd3, 4'h0);
        reg_rd(2'd0, r); chk("R10 addr3 write ignored", r, 4'hF);
        reg_rd(2'd0, r); chk("R10 read has no side effect", r, 4'hF);
        reg_wr(2'd0, 4'h0);
        chk("R9 lock_err cleared", lock_err, 0);
    endtask

    task automatic t_parity_filter();
        logic [3:0] r;
        logic [DATA_W-1:0] d = 32'h1234_5678;
        reg_wr(2'd0, 4'h5);
        bus(1, d, good_par(d), 0);
        reg_rd(2'd1, r); chk("R1 good parity not logged", r, 0);
        bus(0, d, ~good_par(d), 0);
        reg_rd(2'd1, r); chk("R1 bad parity without write valid", r, 0);
        reg_wr(2'd0, 4'h4);
        bus(1, d, ~good_par(d), 0);
        reg_rd(2'd1, r); chk("R2 parity enable clear", r, 0);
        chk("R5 no mcheck when not logged", mcheck_n, 1);
    endtask

    task automatic t_parity_log_and_block();
        logic [3:0] r;
        logic [DATA_W-1:0] d = 32'h0000_00FF;
        logic [LANES-1:0]  p = good_par(d) ^ 4'b0001;
        reg_wr(2'd0, 4'h7);
        bus(1, d, p, 0);
        reg_rd(2'd1, r); chk("R2 parity error logged", r, 4'h1);
        chk("R5 mcheck low cycle 1", mcheck_n, 0);
        @(negedge clk); chk("R5 mcheck low cycle 2", mcheck_n, 0);
        @(negedge clk); chk("R5 mcheck released", mcheck_n, 1);
        bus(0, '0, '0, 1);
        reg_rd(2'd1, r); chk("R6 merr blocked while pending", r, 4'h1);
        chk("R6 no mcheck while blocked", mcheck_n, 1);
        reg_wr(2'd1, 4'h0);
        reg_rd(2'd1, r); chk("R8 write 0 no effect", r, 4'h1);
        reg_wr(2'd1, 4'h2);
        reg_rd(2'd1, r); chk("R8 clearing other bit no effect", r, 4'h1);
        reg_wr(2'd1, 4'h1);
        reg_rd(2'd1, r); chk("R8 write 1 clears", r, 0);
    endtask

    task automatic t_merr_no_mc();
        logic [3:0] r;
        reg_wr(2'd0, 4'h2);
        bus(0, '0, '0, 1);
        reg_rd(2'd1, r); chk("R3 merr logged", r, 4'h2);
        chk("R5 mcheck stays high with mc disabled", mcheck_n, 1);
        @(negedge clk); chk("R5 mcheck still high", mcheck_n, 1);
        reg_wr(2'd1, 4'h2);
    endtask

    task automatic t_simultaneous();
        logic [3:0] r;
        logic [DATA_W-1:0] d = 32'hA5A5_0F0F;
        reg_wr(2'd0, 4'h7);
        bus(1, d, good_par(d) ^ 4'b1000, 1);
        reg_rd(2'd1, r); chk("R7 both bits logged", r, 4'h3);
        chk("R5 mcheck low on dual log", mcheck_n, 0);
        repeat (3) @(negedge clk);
        reg_wr(2'd1, 4'h3);
        reg_rd(2'd1, r); chk("R8 both cleared", r, 0);
    endtask

    task automatic t_clear_race();
        logic [3:0] r;
        reg_wr(2'd0, 4'h2);
        bus(0, '0, '0, 1);
        reg_rd(2'd1, r); chk("R3 merr logged before race", r, 4'h2);
        @(negedge clk);
        reg_we = 1; reg_addr = 2'd1; reg_wdata = 4'h2; merr = 1;
        @(negedge clk);
        reg_we = 0; merr = 0;
        reg_rd(2'd1, r); chk("R6 error during clear dropped", r, 0);
        bus(0, '0, '0, 1);
        reg_rd(2'd1, r); chk("R6 logging resumes after clear", r, 4'h2);
        reg_wr(2'd1, 4'h2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_regmap();
        t_parity_filter();
        t_parity_log_and_block();
        t_merr_no_mc();
        t_simultaneous();
        t_clear_race();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule